// File: doc/BRIEF.md
# Third-Order One-Bit Noise-Shaping Modulator

This block turns a stream of signed 22-bit words, already interpolated to 32 times the audio sample rate, into a single-bit pulse-density stream at 128 times the sample rate. Each word is captured when its strobe is high. It stays in force while the modulator advances on the following clock-enable pulses, so every word is repeated over four output periods. This zero-order hold supplies the final factor of four in rate. One instance serves one channel.

The loop is a chain of three delaying integrators. The output bit is fed back to each integrator as a signed full-scale value, and the output bit is the sign of the last integrator. All gains are powers of two, so the loop uses only shifts and adders. Every integrator adds with saturation inside six guard bits, so an overdriven loop clamps instead of wrapping. Downstream, the bit picks the polarity of a fixed charge packet in a switched-capacitor converter.

Top module: `dsm3_mod`

## Requirements
- R1: A synchronous reset clears the held word and all three integrators. While reset is high and on the first cycle after it, bit_out is 1. The bit stream that follows a reset depends only on the stimulus applied after that reset.
- R2: A 1 on bit_out stands for a feedback of +2^21 and a 0 stands for -2^21. On each enabled step, the first integrator changes by the held word minus that feedback. A positive held word gives more ones than zeros, and a negative held word gives fewer.
- R3: A high in_valid loads in_data into the hold register at that clock edge, whether or not ce is high. Without a strobe, the held word does not change, whatever in_data does.
- R4: The modulator advances only on clock edges where ce is high. While ce is low, bit_out and all integrator states stay unchanged, so idle gaps between enabled steps do not alter the sequence of output bits.
- R5: For a held word u with |u| <= 3*2^18, the number of ones over 4096 enabled steps is 2048 + 2048*u/2^21, within 66.
- R6: Each integrator saturates at its 28-bit signed limits. A held word at positive full scale (2^21-1) gives at least 97% ones, and one at negative full scale (-2^21) gives at most 3% ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Modulator step enable at 128 times the sample rate |
| in_valid | input | 1 | Strobe that loads in_data into the hold register |
| in_data | input | 22 | Signed two's-complement input word |
| bit_out | output | 1 | Pulse-density output, 1 for positive feedback |

## Verification
The feedback checks depend on one input property. Any 22-bit word minus a positive full-scale feedback is negative, and any word plus a negative full-scale feedback is at least zero, so the first integrator must move against the output bit. That holds for every legal input, so no stimulus is excluded there. The density and repeatability checks assume the loop stays stable. For that reason, held words in the linear tests stay within three eighths of full scale, and only the saturation tests drive the extremes. Strobes arrive every fourth step with the same word, as an upstream interpolator would send them, and idle gaps are inserted only with ce low.

// File: rtl/dsm3_pkg.sv
package dsm3_pkg;

    // Output polarity: 1 selects the positive reference packet.
    typedef enum logic {
        FB_NEG = 1'b0,
        FB_POS = 1'b1
    } fb_pol_e;

    // Fewest guard bits that keep the integrators from clipping in normal use.
    localparam int MIN_GUARD_W = 6;

endpackage

// File: rtl/dsm3_hold.sv
module dsm3_hold #(
    parameter int DATA_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } hold_s;

    hold_s hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d.word = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign dout = hold_q.word;

endmodule

// File: rtl/dsm3_integ.sv
module dsm3_integ #(
    parameter int ST_W  = 28,
    parameter int INC_W = 30
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  logic signed [INC_W-1:0] inc,
    output logic signed [ST_W-1:0]  st
);

    localparam int EXT_W = INC_W - ST_W;
    localparam logic signed [INC_W-1:0] MAX_V =
        {{(EXT_W + 1){1'b0}}, {(ST_W - 1){1'b1}}};
    localparam logic signed [INC_W-1:0] MIN_V =
        {{(EXT_W + 1){1'b1}}, {(ST_W - 1){1'b0}}};

    typedef struct packed {
        logic signed [ST_W-1:0] acc;
    } integ_s;

    integ_s integ_d, integ_q;
    logic signed [INC_W-1:0] sum_c;

    always_comb begin
        integ_d = integ_q;
        sum_c   = $signed({{EXT_W{integ_q.acc[ST_W-1]}}, integ_q.acc}) + inc;
        if (ce) begin
            if (sum_c > MAX_V) begin
                integ_d.acc = MAX_V[ST_W-1:0];
            end else if (sum_c < MIN_V) begin
                integ_d.acc = MIN_V[ST_W-1:0];
            end else begin
                integ_d.acc = sum_c[ST_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q <= '0;
        end else begin
            integ_q <= integ_d;
        end
    end

    assign st = integ_q.acc;

endmodule

// File: rtl/dsm3_mod.sv
module dsm3_mod #(
    parameter int DATA_W  = 22,
    parameter int GUARD_W = 6,
    parameter int SHIFT1  = 4,
    parameter int SHIFT2  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              bit_out
);

    import dsm3_pkg::*;

    localparam int ST_W   = DATA_W + GUARD_W;
    localparam int INC_W  = ST_W + 2;
    localparam int ORDER  = 3;
    localparam logic signed [INC_W-1:0] FS =
        {{(INC_W - DATA_W){1'b0}}, 1'b1, {(DATA_W - 1){1'b0}}};

    typedef struct packed {
        logic signed [INC_W-1:0] fb;
        logic signed [INC_W-1:0] inc0;
        logic signed [INC_W-1:0] inc1;
        logic signed [INC_W-1:0] inc2;
    } loop_s;

    logic [DATA_W-1:0]       held;
    logic signed [ST_W-1:0]  st_arr  [ORDER];
    logic signed [INC_W-1:0] inc_arr [ORDER];
    logic signed [ST_W-1:0]  x1_st;
    fb_pol_e                 pol;
    loop_s                   loop_d;

    dsm3_hold #(
        .DATA_W(DATA_W)
    ) i_hold (
        .clk  (clk),
        .rst  (rst),
        .load (in_valid),
        .din  (in_data),
        .dout (held)
    );

    // Output polarity is the sign of the last integrator (zero counts as positive).
    assign pol     = st_arr[ORDER-1][ST_W-1] ? FB_NEG : FB_POS;
    assign bit_out = (pol == FB_POS);
    assign x1_st   = st_arr[0];

    always_comb begin
        loop_d.fb   = (pol == FB_POS) ? FS : -FS;
        loop_d.inc0 = INC_W'($signed(held)) - loop_d.fb;
        loop_d.inc1 = INC_W'(st_arr[0] >>> SHIFT1) - (loop_d.fb >>> SHIFT2);
        loop_d.inc2 = INC_W'(st_arr[1]) - loop_d.fb;
    end

    assign inc_arr[0] = loop_d.inc0;
    assign inc_arr[1] = loop_d.inc1;
    assign inc_arr[2] = loop_d.inc2;

    generate
        for (genvar g = 0; g < ORDER; g++) begin : g_stage
            dsm3_integ #(
                .ST_W  (ST_W),
                .INC_W (INC_W)
            ) i_integ (
                .clk (clk),
                .rst (rst),
                .ce  (ce),
                .inc (inc_arr[g]),
                .st  (st_arr[g])
            );
        end
    endgenerate

endmodule

// File: rtl/dsm3_mod_chk.sv
module dsm3_mod_chk #(
    parameter int DATA_W  = 22,
    parameter int GUARD_W = 6
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              ce,
    input logic                              in_valid,
    input logic [DATA_W-1:0]                 in_data,
    input logic [DATA_W-1:0]                 held,
    input logic                              bit_out,
    input logic signed [DATA_W+GUARD_W-1:0]  x1
);

    localparam int ST_W = DATA_W + GUARD_W;
    localparam logic signed [ST_W-1:0] X1_MIN = {1'b1, {(ST_W - 1){1'b0}}};

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (bit_out && x1 == '0));

    // R2
    feedback_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && bit_out && x1 != X1_MIN) |=> (x1 < $past(x1)));

    // R2
    feedback_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && !bit_out) |=> (x1 >= $past(x1)));

    // R3
    hold_load_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (held == $past(in_data)));

    // R3
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(held));

    // R4
    ce_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(bit_out) && $stable(x1)));

endmodule

bind dsm3_mod dsm3_mod_chk #(
    .DATA_W  (DATA_W),
    .GUARD_W (GUARD_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .in_valid (in_valid),
    .in_data  (in_data),
    .held     (held),
    .bit_out  (bit_out),
    .x1       (x1_st)
);

// File: tb/test_dsm3_mod.sv
module test_dsm3_mod;

    localparam int DATA_W = 22;
    localparam int FSV    = 2097152;
    localparam int SETTLE = 512;
    localparam int WIN    = 4096;
    localparam int TOL    = 66;
    localparam int REC_N  = 300;
    localparam int VEC_N  = 6;
    localparam int VEC_U    [VEC_N] = '{0, 524288, -524288, 786432, -786432, 262144};
    localparam int VEC_ONES [VEC_N] = '{2048, 2560, 1536, 2816, 1280, 2304};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              bit_out;

    int checks = 0;
    int errors = 0;
    logic rec_a [REC_N];

    always #5 clk = ~clk;

    dsm3_mod i_dsm3_mod (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .in_valid (in_valid),
        .in_data  (in_data),
        .bit_out  (bit_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ce = 1'b0; in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(bit_out == 1'b1, "R1", "bit_out during reset", int'(bit_out), 1);
        rst = 1'b0;
    endtask

    // One enabled step; optionally strobes val in the same cycle.
    task automatic step(input bit strobe, input int val, output logic b);
        ce = 1'b1;
        in_valid = strobe;
        if (strobe) in_data = DATA_W'(val);
        @(posedge clk);
        @(negedge clk);
        ce = 1'b0;
        in_valid = 1'b0;
        b = bit_out;
    endtask

    task automatic run(input int n, input int val, input bit strobes, output int ones);
        logic b;
        ones = 0;
        for (int k = 0; k < n; k++) begin
            step(strobes && (k % 4 == 0), val, b);
            ones += int'(b);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ones;
        int mism;
        logic b;
        logic hold_b;

        // R1: reset state and first bit after release
        do_reset();
        @(posedge clk);
        @(negedge clk);
        chk(bit_out == 1'b1, "R1", "bit_out after reset", int'(bit_out), 1);

        // Reference stream after a clean reset
        for (int k = 0; k < REC_N; k++) begin
            step(k % 4 == 0, 262144, b);
            rec_a[k] = b;
        end

        // Vector table: R5 density, R2 sign
        for (int v = 0; v < VEC_N; v++) begin
            do_reset();
            run(SETTLE, VEC_U[v], 1'b1, ones);
            run(WIN, VEC_U[v], 1'b1, ones);
            chk((ones >= VEC_ONES[v] - TOL) && (ones <= VEC_ONES[v] + TOL),
                "R5", "ones in window", ones, VEC_ONES[v]);
            if (VEC_U[v] > 0)
                chk(ones > WIN / 2, "R2", "positive input majority ones", ones, WIN / 2);
            else if (VEC_U[v] < 0)
                chk(ones < WIN / 2, "R2", "negative input minority ones", ones, WIN / 2);
        end

        // R6: saturation at both full-scale extremes
        do_reset();
        run(SETTLE, FSV - 1, 1'b1, ones);
        run(2048, FSV - 1, 1'b1, ones);
        chk(ones >= 1987, "R6", "ones at +full scale", ones, 1987);
        do_reset();
        run(SETTLE, -FSV, 1'b1, ones);
        run(2048, -FSV, 1'b1, ones);
        chk(ones <= 61, "R6", "ones at -full scale", ones, 61);

        // R3: word loaded once, later in_data changes without strobe are ignored
        do_reset();
        step(1'b1, -524288, b);
        in_data = DATA_W'(524288);
        run(SETTLE, 0, 1'b0, ones);
        in_data = DATA_W'(-FSV);
        run(WIN, 0, 1'b0, ones);
        chk((ones >= 1536 - TOL) && (ones <= 1536 + TOL),
            "R3", "ones with unstrobed input changes", ones, 1536);

        // R3: strobe with ce low still loads
        do_reset();
        @(negedge clk);
        in_valid = 1'b1; in_data = DATA_W'(524288);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_data = DATA_W'(-524288);
        run(SETTLE, 0, 1'b0, ones);
        run(WIN, 0, 1'b0, ones);
        chk((ones >= 2560 - TOL) && (ones <= 2560 + TOL),
            "R3", "ones after load with ce low", ones, 2560);

        // R1: reset from a dirty state reproduces the reference stream
        do_reset();
        mism = 0;
        for (int k = 0; k < REC_N; k++) begin
            step(k % 4 == 0, 262144, b);
            if (b !== rec_a[k]) mism++;
        end
        chk(mism == 0, "R1", "stream mismatches after reset", mism, 0);

        // R4: idle gaps do not change the stream; output frozen while idle
        do_reset();
        mism = 0;
        for (int k = 0; k < REC_N; k++) begin
            step(k % 4 == 0, 262144, b);
            if (b !== rec_a[k]) mism++;
            hold_b = b;
            for (int g = 0; g < (k % 3); g++) begin
                in_data = DATA_W'(k * 977);
                @(posedge clk);
                @(negedge clk);
                if (bit_out !== hold_b) mism++;
            end
        end
        chk(mism == 0, "R4", "mismatches with idle gaps", mism, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule